// File: doc/BRIEF.md
# Boot memory remap controller

This unit sits on the system bus, between the bus master's address output and the slave address decoder. It decides which memory answers in a small window at the bottom of the address map. After reset the window is backed by the boot ROM, so the processor's first fetches (initial stack pointer, reset vector, boot code) come from the ROM. Boot software then writes a control register to back the window with user flash or with an SRAM block. SRAM gives wait-state-free execution and a vector table that can be changed at run time.

Only addresses inside the window are rewritten. A rewritten address keeps its offset and takes the home base of the selected memory. Every other address goes through untouched, so each memory also stays reachable at its own home address. Boot code can set a sticky lock bit that freezes the mapping until the next reset. The register sits behind a simple APB-style port, and the window size and the three home bases are parameters.

A mapping change never moves a transfer that is already on the bus. An address phase that is being stretched by wait states keeps the target it started with. Only address phases that start after the register write completes see the new target.

Top module: `boot_remap`

## Requirements
- R1: After reset the control register reads 0 (mode 2'b00, unlocked), and an address inside the window (upper bits above the window offset all zero) is sent out as ROM_BASE plus its offset.
- R2: The mode field is pwdata[1:0] / prdata[1:0]. Mode 2'b00 maps the window to ROM_BASE, 2'b01 to FLASH_BASE and 2'b10 to SRAM_BASE. The offset inside the window is always kept.
- R3: An address outside the window, including a home address of any of the three memories, appears unchanged on m_haddr in every mode.
- R4: A write with mode value 2'b11 leaves the mode and the mapping unchanged. The lock bit in the same write still takes effect.
- R5: The lock bit is pwdata[2] / prdata[2]. Once set, it stays set, and every later write is ignored until reset. After reset the block is unlocked.
- R6: A register write completes on the clock edge where psel, penable and pwrite are all high. An address phase that starts after that edge uses the new mapping. An address phase that is held by s_hready low (s_htrans 2'b10 or 2'b11) keeps the mapping it started with until s_hready is high.
- R7: While psel is high, prdata shows {0..., lock, mode}. Bits above bit 2 read 0, and prdata is 0 while psel is low.
- R8: A cycle with psel high but penable low, or with pwrite low, changes neither the mode nor the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write strobe |
| pwdata | input | 3 | Write data: [2] lock, [1:0] mode |
| prdata | output | DW | Read data: [2] lock, [1:0] mode |
| s_haddr | input | AW | Address from the bus master |
| s_htrans | input | 2 | Transfer type from the bus master |
| s_hready | input | 1 | Bus ready; high ends the current address phase |
| m_haddr | output | AW | Address to the slave decoder |

## Verification
A wrong mode or lock state shows up as soon as the next address phase in the window is issued. In the same cycle, m_haddr carries the wrong upper bits. A control write that is missed or taken by mistake shows up at once on a register read. A wrong held mode during a stalled phase makes m_haddr change in the middle of the phase, in the cycle right after the write edge. The bench therefore samples m_haddr in each stalled cycle around a write, and in the first unstalled phase after it.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    MAP_ROM   = 2'b00,
    MAP_FLASH = 2'b01,
    MAP_SRAM  = 2'b10,
    MAP_RSVD  = 2'b11
  } map_sel_e;
endpackage

// File: rtl/remap_ctrl_regs.sv
module remap_ctrl_regs
  import remap_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [2:0]    pwdata,
  output logic [DW-1:0] prdata,
  output map_sel_e      mode_o,
  output logic          lock_o
);
  map_sel_e mode_q;
  logic     lock_q;
  logic     wr;

  assign wr = psel && penable && pwrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MAP_ROM;
      lock_q <= 1'b0;
    end else if (wr && !lock_q) begin
      if (pwdata[1:0] != 2'b11) mode_q <= map_sel_e'(pwdata[1:0]);
      if (pwdata[2]) lock_q <= 1'b1;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) prdata[2:0] = {lock_q, mode_q};
  end

  assign mode_o = mode_q;
  assign lock_o = lock_q;

  // R5: the lock never clears while out of reset
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  // R5: a locked register keeps its mode
  p_locked_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(mode_q));
  // R4: the reserved code does not move the mode
  p_rsvd_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && pwdata[1:0] == 2'b11) |=> $stable(mode_q));
  // R8: without a completed write nothing changes
  p_idle_nochange_r8: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(mode_q) && $stable(lock_q)));
endmodule

// File: rtl/remap_phase.sv
module remap_phase
  import remap_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     trans_active,
  input  logic     hready,
  input  map_sel_e live_mode,
  output map_sel_e eff_mode
);
  logic     stall_q;
  map_sel_e held_q;

  // A stalled phase continues with the mode it was presented with.
  assign eff_mode = stall_q ? held_q : live_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q <= 1'b0;
      held_q  <= MAP_ROM;
    end else begin
      stall_q <= trans_active && !hready;
      held_q  <= eff_mode;
    end
  end

  // R6: the mode seen by the bus cannot change inside a stalled phase
  p_held_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (trans_active && !hready) |=> (eff_mode == $past(eff_mode)));
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          WIN_BYTES  = 16384,
  parameter logic [31:0] ROM_BASE   = 32'h1FFF_0000,
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000
) (
  input  logic [AW-1:0] addr_i,
  input  map_sel_e      mode_i,
  output logic [AW-1:0] addr_o
);
  localparam int OFF_W = $clog2(WIN_BYTES);

  logic          in_win;
  logic [AW-1:0] base;
  logic [AW-1:0] offset;

  assign in_win = ~|addr_i[AW-1:OFF_W];
  assign offset = {{(AW-OFF_W){1'b0}}, addr_i[OFF_W-1:0]};

  always_comb begin
    unique case (mode_i)
      MAP_ROM:   base = AW'(ROM_BASE);
      MAP_FLASH: base = AW'(FLASH_BASE);
      MAP_SRAM:  base = AW'(SRAM_BASE);
      default:   base = '0;
    endcase
  end

  assign addr_o = in_win ? (base | offset) : addr_i;
endmodule

// File: rtl/boot_remap.sv
module boot_remap
  import remap_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int          WIN_BYTES  = 16384,
  parameter logic [31:0] ROM_BASE   = 32'h1FFF_0000,
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [2:0]    pwdata,
  output logic [DW-1:0] prdata,
  input  logic [AW-1:0] s_haddr,
  input  logic [1:0]    s_htrans,
  input  logic          s_hready,
  output logic [AW-1:0] m_haddr
);
  localparam int OFF_W = $clog2(WIN_BYTES);

  map_sel_e reg_mode;
  map_sel_e bus_mode;
  logic     reg_lock;
  logic     trans_active;

  assign trans_active = (s_htrans == 2'b10) || (s_htrans == 2'b11);

  remap_ctrl_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .prdata(prdata), .mode_o(reg_mode), .lock_o(reg_lock)
  );

  remap_phase u_phase (
    .clk(clk), .rst(rst), .trans_active(trans_active), .hready(s_hready),
    .live_mode(reg_mode), .eff_mode(bus_mode)
  );

  remap_xlate #(
    .AW(AW), .WIN_BYTES(WIN_BYTES), .ROM_BASE(ROM_BASE),
    .FLASH_BASE(FLASH_BASE), .SRAM_BASE(SRAM_BASE)
  ) u_xlate (
    .addr_i(s_haddr), .mode_i(bus_mode), .addr_o(m_haddr)
  );

  // R2: the offset inside the window survives translation
  p_offset_kept_r2: assert property (@(posedge clk) disable iff (rst)
    m_haddr[OFF_W-1:0] == s_haddr[OFF_W-1:0]);
  // R3: addresses outside the window pass untouched
  p_pass_outside_r3: assert property (@(posedge clk) disable iff (rst)
    (|s_haddr[AW-1:OFF_W]) |-> (m_haddr == s_haddr));
  // R1 / R2: a window address always lands on one of the three home bases
  p_window_home_r2: assert property (@(posedge clk) disable iff (rst)
    (~|s_haddr[AW-1:OFF_W]) |->
      (m_haddr[AW-1:OFF_W] == AW'(ROM_BASE) >> OFF_W ||
       m_haddr[AW-1:OFF_W] == AW'(FLASH_BASE) >> OFF_W ||
       m_haddr[AW-1:OFF_W] == AW'(SRAM_BASE) >> OFF_W));
  // R6: a held address phase keeps its translated address
  p_stall_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (trans_active && !s_hready) |=> (!$stable(s_haddr) || $stable(m_haddr)));
  // R5: the lock state shows on the read port
  p_lock_visible_r5: assert property (@(posedge clk) disable iff (rst)
    psel |-> (prdata[2] == reg_lock));
endmodule

// File: tb/boot_remap_tb_top.sv
module boot_remap_tb_top;
  localparam int          AW    = 32;
  localparam int          DW    = 32;
  localparam int          WIN   = 16384;
  localparam logic [31:0] ROMB  = 32'h1FFF_0000;
  localparam logic [31:0] FLB   = 32'h0800_0000;
  localparam logic [31:0] SRB   = 32'h2000_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [2:0]    pwdata = '0;
  logic [DW-1:0] prdata;
  logic [AW-1:0] s_haddr = '0;
  logic [1:0]    s_htrans = 2'b00;
  logic          s_hready = 1'b1;
  logic [AW-1:0] m_haddr;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] e_mode = 2'b00;
  logic       e_lock = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  boot_remap #(.AW(AW), .DW(DW), .WIN_BYTES(WIN), .ROM_BASE(ROMB),
               .FLASH_BASE(FLB), .SRAM_BASE(SRB)) dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .prdata(prdata), .s_haddr(s_haddr), .s_htrans(s_htrans),
    .s_hready(s_hready), .m_haddr(m_haddr)
  );

  function automatic logic [31:0] exp_addr(logic [1:0] md, logic [31:0] a);
    logic [31:0] b;
    if (a >= WIN) return a;
    case (md)
      2'b01:   b = FLB;
      2'b10:   b = SRB;
      default: b = ROMB;
    endcase
    return b | a;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    e_mode = 2'b00; e_lock = 1'b0;
  endtask

  task automatic apb_write(logic [2:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; penable = 1'b0; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    if (!e_lock) begin
      if (d[1:0] != 2'b11) e_mode = d[1:0];
      if (d[2]) e_lock = 1'b1;
    end
  endtask

  task automatic apb_read(string tag);
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; penable = 1'b0;
    #1 chk(tag, prdata, {29'd0, e_lock, e_mode});
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic bus_check(string tag, logic [31:0] a);
    @(negedge clk); s_haddr = a; s_htrans = 2'b10; s_hready = 1'b1;
    #1 chk(tag, m_haddr, exp_addr(e_mode, a));
    s_htrans = 2'b00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    apb_read("R1 reset readback");
    bus_check("R1 window at reset", 32'h0000_0004);
    bus_check("R1 window top at reset", 32'h0000_3FFC);
    // R7 prdata zero while not selected
    @(negedge clk); #1 chk("R7 prdata idle", prdata, 32'd0);
    // R2 each mode
    apb_write(3'b001); bus_check("R2 flash", 32'h0000_0100);
    apb_write(3'b010); bus_check("R2 sram", 32'h0000_2468);
    apb_read("R7 readback sram");
    apb_write(3'b000); bus_check("R2 rom again", 32'h0000_0010);
    // R3 outside window, incl. home addresses
    bus_check("R3 first outside", 32'h0000_4000);
    bus_check("R3 flash home", FLB | 32'h20);
    bus_check("R3 sram home", SRB | 32'h1000);
    // R4 reserved code
    apb_write(3'b001);
    apb_write(3'b011); bus_check("R4 reserved keeps map", 32'h0000_0040);
    apb_read("R4 reserved readback");
    // R8 setup-only cycle and read access do not write
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; penable = 1'b0; pwdata = 3'b110;
    @(negedge clk); psel = 1'b0; pwrite = 1'b0;
    apb_read("R8 setup-only ignored");
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; penable = 1'b1; pwdata = 3'b110;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
    bus_check("R8 read access ignored", 32'h0000_0080);
    // R6 stalled phase keeps old target across a write
    apb_write(3'b000);
    @(negedge clk);
    s_haddr = 32'h0000_0100; s_htrans = 2'b10; s_hready = 1'b0;
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; pwdata = 3'b001;
    #1 chk("R6 stall start", m_haddr, ROMB | 32'h100);
    @(negedge clk); penable = 1'b1;
    #1 chk("R6 stall before edge", m_haddr, ROMB | 32'h100);
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    #1 chk("R6 stall after edge", m_haddr, ROMB | 32'h100);
    s_hready = 1'b1;
    #1 chk("R6 stall last cycle", m_haddr, ROMB | 32'h100);
    e_mode = 2'b01;
    @(negedge clk); s_haddr = 32'h0000_0200;
    #1 chk("R6 next phase new map", m_haddr, FLB | 32'h200);
    s_htrans = 2'b00;
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      if ($urandom_range(0, 2) == 0) apb_write({1'b0, 2'($urandom)});
      a = $urandom;
      if ($urandom_range(0, 1) == 0) a = a & 32'h3FFF;
      else if (a < WIN) a = a + WIN;
      bus_check(a < WIN ? "R2 random window" : "R3 random outside", a);
      if (i % 50 == 0) apb_read("R7 random readback");
    end
    // R5 lock
    apb_write(3'b110);
    apb_read("R5 lock set");
    apb_write(3'b000); apb_write(3'b001);
    apb_read("R5 locked readback");
    bus_check("R5 locked map", 32'h0000_0ABC);
    do_reset();
    apb_read("R5 unlocked after reset");
    apb_write(3'b001); bus_check("R5 writable after reset", 32'h0000_0004);
    finish_run();
  end
endmodule